// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block performs one 8-bit arithmetic or logic operation per clock on two operands and an incoming status byte. It returns the 8-bit result and a new status byte. Eight operations are selected by a 3-bit code: plain add, add with carry-in, plain subtract, subtract with borrow-in, bitwise AND, OR, exclusive-OR, and arithmetic shift right of the first operand.

Each operation writes its own set of flags. Flags outside that set keep the value they had in the incoming status byte. The two control bits at the top of the status byte are never altered. Result and status are registered, so they appear one cycle after the operands are presented. A core pipeline feeds operands and status in each cycle and writes back both outputs.

Top module: `byte_alu`

## Requirements
- R1: Opcode encoding on `op_i` is 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 arithmetic shift right. `res_o` and `sreg_o` present the outcome of the inputs sampled at the previous rising edge. While `rst` is high, both outputs are cleared to zero.
- R2: Add gives (a + b) mod 256 and add with carry gives (a + b + status bit 0) mod 256. Carry (status bit 0) is set when the true sum exceeds 255.
- R3: Subtract gives (a − b) mod 256 and subtract with borrow gives (a − b − status bit 0) mod 256. Carry is set when b plus the borrow-in is greater than a as unsigned numbers.
- R4: Half carry (status bit 5) is set for add operations when the low-nibble sum carries into bit 4. For subtract operations it is set when the low nibble borrows from bit 4.
- R5: Overflow (status bit 3) for add is set when a and b share a sign bit and the result sign differs. For subtract it is set when the signs of a and b differ and the result sign differs from a.
- R6: AND, OR and XOR clear overflow and leave carry and half carry equal to their incoming values.
- R7: Shift right keeps bit 7 of a, moves a[0] into carry, sets overflow to negative XOR carry, and leaves half carry unchanged. The b operand is unused.
- R8: Negative (status bit 2) equals bit 7 of the result for every operation.
- R9: Zero (status bit 1) is set exactly when all eight result bits are zero, for every operation.
- R10: Sign (status bit 4) equals the new negative XOR the new overflow for every operation.
- R11: Status bits 7 (interrupt enable) and 6 (transfer bit) are copied from the incoming status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| opa_i | input | 8 | First operand, also the shift source |
| opb_i | input | 8 | Second operand |
| sreg_i | input | 8 | Incoming status byte |
| res_o | output | 8 | Registered result |
| sreg_o | output | 8 | Registered updated status byte |

## Verification
Operand pairs at the extremes (0x00, 0x7F, 0x80, 0xFF and nibble edges 0x0F/0x10) are applied with carry-in both set and clear. This separates signed overflow from unsigned carry, and half carry from full carry. Zero results come from equal operands and from wraparound, so the zero flag is checked both with and without a carry. Logic and shift operations run with incoming status bytes of all ones and all zeros, which shows that preserved flags really come from the input. Random operand and status patterns then cover every code, and an independent arithmetic model checks each field on every cycle.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_SHR  = 3'd7
    } alu_op_e;

    // Bit order is the status byte layout seen by neighbouring logic.
    typedef struct packed {
        logic ien;
        logic xfer;
        logic half;
        logic sgn;
        logic ovf;
        logic neg;
        logic zero;
        logic cy;
    } status_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBB);
    endfunction

    function automatic logic is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBB);
    endfunction

    function automatic logic uses_cin(alu_op_e op);
        return (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

    // Which status fields an operation writes; zeros keep the old value.
    function automatic status_t write_mask(alu_op_e op);
        status_t m;
        m = '0;
        m.sgn  = 1'b1;
        m.ovf  = 1'b1;
        m.neg  = 1'b1;
        m.zero = 1'b1;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                m.cy   = 1'b1;
                m.half = 1'b1;
            end
            OP_SHR:  m.cy = 1'b1;
            default: m.cy = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         half,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [W:0]    full_sum;
    logic [HW:0]   nib_sum;

    // Subtraction as a + ~b + (1 - borrow); carries invert into borrows.
    always_comb begin
        b_eff    = sub ? ~b : b;
        c_eff    = sub ? ~cin : cin;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        nib_sum  = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        res      = full_sum[W-1:0];
        cy       = sub ? ~full_sum[W] : full_sum[W];
        half     = sub ? ~nib_sum[HW] : nib_sum[HW];
        ovf      = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/byte_alu_bitops.sv
module byte_alu_bitops
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         shift_out
);
    logic [W-1:0] shr_v;

    assign shr_v[W-1] = a[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_shr
        assign shr_v[i] = a[i+1];
    end

    assign shift_out = a[0];

    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SHR:  res = shr_v;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/byte_alu_flagmerge.sv
module byte_alu_flagmerge
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  status_t      old_s,
    input  logic [W-1:0] ar_res,
    input  logic         ar_cy,
    input  logic         ar_half,
    input  logic         ar_ovf,
    input  logic [W-1:0] lg_res,
    input  logic         lg_shift_out,
    output logic [W-1:0] res,
    output status_t      new_s
);
    status_t calc;
    status_t mask;

    always_comb begin
        calc      = '0;
        res       = is_arith(op) ? ar_res : lg_res;
        calc.neg  = res[W-1];
        calc.zero = ~|res;
        if (is_arith(op)) begin
            calc.cy   = ar_cy;
            calc.half = ar_half;
            calc.ovf  = ar_ovf;
        end else if (op == OP_SHR) begin
            calc.cy   = lg_shift_out;
            calc.ovf  = res[W-1] ^ lg_shift_out;
        end else begin
            calc.ovf  = 1'b0;
        end
        calc.sgn  = calc.neg ^ calc.ovf;
        mask      = write_mask(op);
        new_s     = (calc & mask) | (old_s & ~mask);
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [7:0]   sreg_i,
    output logic [W-1:0] res_o,
    output logic [7:0]   sreg_o
);
    alu_op_e      op;
    status_t      s_in;
    logic [W-1:0] ar_res, lg_res, res_d;
    logic         ar_cy, ar_half, ar_ovf, lg_so;
    status_t      s_d;
    logic [W-1:0] res_q;
    status_t      s_q;

    assign op   = alu_op_e'(op_i);
    assign s_in = status_t'(sreg_i);

    byte_alu_addsub #(.W(W)) u_addsub (
        .a    (opa_i),
        .b    (opb_i),
        .sub  (is_sub(op)),
        .cin  (uses_cin(op) & s_in.cy),
        .res  (ar_res),
        .cy   (ar_cy),
        .half (ar_half),
        .ovf  (ar_ovf)
    );

    byte_alu_bitops #(.W(W)) u_bitops (
        .op        (op),
        .a         (opa_i),
        .b         (opb_i),
        .res       (lg_res),
        .shift_out (lg_so)
    );

    byte_alu_flagmerge #(.W(W)) u_merge (
        .op           (op),
        .old_s        (s_in),
        .ar_res       (ar_res),
        .ar_cy        (ar_cy),
        .ar_half      (ar_half),
        .ar_ovf       (ar_ovf),
        .lg_res       (lg_res),
        .lg_shift_out (lg_so),
        .res          (res_d),
        .new_s        (s_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            s_q   <= '0;
        end else begin
            res_q <= res_d;
            s_q   <= s_d;
        end
    end

    assign res_o  = res_q;
    assign sreg_o = s_q;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_i,
    input logic [W-1:0] opa_i,
    input logic [7:0]   sreg_i,
    input logic [W-1:0] res_o,
    input logic [7:0]   sreg_o
);
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R1: outputs held at zero during reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (res_o == '0 && sreg_o == 8'h00));

    a_r8_neg_bit: assert property (@(posedge clk) disable iff (rst)
        primed |-> sreg_o[2] == res_o[W-1]);

    a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
        primed |-> sreg_o[1] == (res_o == '0));

    a_r10_sign_flag: assert property (@(posedge clk) disable iff (rst)
        primed |-> sreg_o[4] == (sreg_o[2] ^ sreg_o[3]));

    a_r11_ctrl_bits: assert property (@(posedge clk) disable iff (rst)
        primed |-> sreg_o[7:6] == $past(sreg_i[7:6]));

    a_r6_logic_flags: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) >= 3'd4 && $past(op_i) <= 3'd6) |->
        (!sreg_o[3] && sreg_o[0] == $past(sreg_i[0]) && sreg_o[5] == $past(sreg_i[5])));

    a_r7_shift_right: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) == 3'd7) |->
        (res_o == {$past(opa_i[W-1]), $past(opa_i[W-1:1])} && sreg_o[0] == $past(opa_i[0])
         && sreg_o[5] == $past(sreg_i[5])));
endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .opa_i  (opa_i),
    .sreg_i (sreg_i),
    .res_o  (res_o),
    .sreg_o (sreg_o)
);

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = '0;
    logic [7:0] opa_i = '0;
    logic [7:0] opb_i = '0;
    logic [7:0] sreg_i = '0;
    logic [7:0] res_o;
    logic [7:0] sreg_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    byte_alu dut_i (
        .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i),
        .opb_i(opb_i), .sreg_i(sreg_i), .res_o(res_o), .sreg_o(sreg_o)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: returns {status, result}.
    function automatic int model(int op, int a, int b, int s);
        int r, c, h, v, n, z, sg, cin, cy_o, hf_o;
        c = s & 1; h = (s >> 5) & 1; v = 0;
        cy_o = c; hf_o = h;
        cin = (op == 1 || op == 3) ? c : 0;
        case (op)
            0, 1: begin
                r = a + b + cin;
                cy_o = (r > 255) ? 1 : 0;
                hf_o = ((a % 16) + (b % 16) + cin > 15) ? 1 : 0;
                r = r % 256;
                v = ((a >= 128) == (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0;
            end
            2, 3: begin
                cy_o = (b + cin > a) ? 1 : 0;
                hf_o = ((b % 16) + cin > (a % 16)) ? 1 : 0;
                r = (a - b - cin + 512) % 256;
                v = ((a >= 128) != (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0;
            end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            default: begin
                r = (a / 2) + ((a >= 128) ? 128 : 0);
                cy_o = a % 2;
                v = ((r >= 128) ? 1 : 0) ^ cy_o;
            end
        endcase
        n = (r >= 128) ? 1 : 0;
        z = (r == 0) ? 1 : 0;
        sg = n ^ v;
        return (((s & 8'hC0) | (hf_o << 5) | (sg << 4) | (v << 3) | (n << 2) | (z << 1) | cy_o) << 8) | r;
    endfunction

    task automatic apply(int op, int a, int b, int s);
        int e, er, es;
        string rtag;
        @(negedge clk);
        op_i = 3'(op); opa_i = 8'(a); opb_i = 8'(b); sreg_i = 8'(s);
        e = model(op, a, b, s);
        er = e & 255; es = (e >> 8) & 255;
        @(negedge clk);
        rtag = (op < 2) ? "R2" : (op < 4) ? "R3" : (op < 7) ? "R6" : "R7";
        check({rtag, " result"}, res_o, er);
        check((op < 2) ? "R2 carry" : (op < 4) ? "R3 carry" : (op < 7) ? "R6 carry" : "R7 carry",
              sreg_o[0], es & 1);
        check((op < 4) ? "R4 half" : (op < 7) ? "R6 half" : "R7 half", sreg_o[5], (es >> 5) & 1);
        check((op < 4) ? "R5 ovf" : (op < 7) ? "R6 ovf" : "R7 ovf", sreg_o[3], (es >> 3) & 1);
        check("R8 neg", sreg_o[2], (es >> 2) & 1);
        check("R9 zero", sreg_o[1], (es >> 1) & 1);
        check("R10 sign", sreg_o[4], (es >> 4) & 1);
        check("R11 ctrl", sreg_o[7:6], (es >> 6) & 3);
        check("R1 latency/status", sreg_o, es);
    endtask

    initial begin
        int edge_v[6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h0F, 8'h10};
        repeat (3) @(negedge clk);
        check("R1 reset res", res_o, 0);
        check("R1 reset status", sreg_o, 0);
        rst = 1'b0;
        // directed corners
        apply(0, 8'h7F, 8'h01, 8'h00);
        apply(0, 8'hFF, 8'h01, 8'hC0);
        apply(1, 8'hFF, 8'h00, 8'h01);
        apply(1, 8'h0F, 8'h00, 8'h01);
        apply(2, 8'h80, 8'h01, 8'h00);
        apply(2, 8'h10, 8'h10, 8'hFF);
        apply(3, 8'h00, 8'h00, 8'h01);
        apply(3, 8'h05, 8'h04, 8'h01);
        apply(4, 8'hF0, 8'h0F, 8'hFF);
        apply(5, 8'h00, 8'h00, 8'h21);
        apply(6, 8'hAA, 8'hAA, 8'hFF);
        apply(7, 8'h81, 8'h00, 8'h20);
        apply(7, 8'h01, 8'hFF, 8'hFF);
        apply(7, 8'h80, 8'h00, 8'h00);
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    apply(op, edge_v[i], edge_v[j], (i + j) % 2 ? 8'hFF : 8'h00);
        for (int k = 0; k < 600; k++)
            apply($urandom % 8, $urandom % 256, $urandom % 256, $urandom % 256);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule